// File: doc/BRIEF.md
# Lane Stop-State Timeout Controller

This block holds a serial camera receiver's lane I/O in forced receive mode while the link initializes. Software raises a force request. The block then drives the force-receive-mode output high and watches the stop-state indication of each lane whose bit is set in the lane-enable mask. When every enabled lane has been in stop state for long enough, the block releases the force output. It also clears the software force bit and raises a one-cycle done pulse.

The hold time is programmed with a 13-bit count and two scaling bits. The scaling bits multiply the count by 1, 4, 16 or 64. The timer runs only while all enabled lanes sit in stop state together. If any enabled lane leaves stop state, the timer reloads in full and waits for all enabled lanes to be stopped again. Software can cancel the force request at any time with a clear input, which always wins.

Top module: `lane_stop_timeout`

## Requirements
- R1: With the force bit low, a cycle with `sw_set`=1 and `sw_clr`=0 makes `force_rx` and `force_bit` high from the next cycle. The two outputs always carry the same value. A set while the force bit is already high changes nothing.
- R2: A cycle with `sw_clr`=1 makes `force_rx` low from the next cycle and gives no done pulse, whatever the other inputs are. A set in the same cycle as a clear is ignored.
- R3: Bit i of `lane_en` enables bit i of `stop_state`. A stop-state bit whose enable bit is 0 has no effect on the timer.
- R4: A cycle counts as qualifying when the force bit is high and every enabled lane shows stop state. While no cycle qualifies, `force_rx` stays high.
- R5: A non-qualifying cycle while the force bit is high reloads the timer. Counting restarts from the full delay on the next qualifying cycle.
- R6: Let D = count × (1 + 15·x16) × (1 + 3·x4). The force bit falls after the (D+1)-th consecutive qualifying cycle. Counting begins from the first qualifying cycle after a reload or a set.
- R7: A count of zero ends the timeout on the first qualifying cycle.
- R8: `done_pulse` is high for exactly one cycle. That cycle is the first cycle in which `force_rx` is low after a timeout. A fall caused by a clear gives no pulse.
- R9: While reset is asserted, and right after it, `force_rx`, `force_bit` and `done_pulse` are 0.
- R10: The count and the scaling bits are sampled on the first qualifying cycle. Changing them while the timer runs does not change the delay in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_set | input | 1 | Software request to set the force bit |
| sw_clr | input | 1 | Software clear of the force bit (priority) |
| cnt_val | input | 13 | Base timeout count |
| scale_x16 | input | 1 | Multiply the count by 16 |
| scale_x4 | input | 1 | Multiply the count by 4 |
| lane_en | input | 5 | Per-lane monitor enable |
| stop_state | input | 5 | Per-lane stop-state indication, synchronous |
| force_rx | output | 1 | Force-receive-mode drive to the lane I/O |
| force_bit | output | 1 | Readback of the force bit |
| done_pulse | output | 1 | One-cycle pulse on timeout release |

## Verification
Three pairs of events can fall in the same cycle. A software clear can meet the final count of the timer. A lane can leave stop state in the cycle the timer would expire. A set can arrive together with a clear. The directed sections build each of these. The random phase also raises clear and drops lanes often enough to hit them repeatedly. A cycle-level reference model in the bench judges each case. In that model the clear wins over expiry and gives no done pulse. A lane drop on the final cycle reloads the timer instead of finishing it.

// File: rtl/lst_pkg.sv
package lst_pkg;
  localparam int unsigned PRE_W = 6;

  // Prescaler terminal value: step size minus one (step = 1, 4, 16 or 64).
  function automatic logic [PRE_W-1:0] pre_term(input logic x16, input logic x4);
    logic [PRE_W:0] step;
    step = (x16 ? 7'd16 : 7'd1) * (x4 ? 7'd4 : 7'd1);
    return PRE_W'(step - 7'd1);
  endfunction
endpackage

// File: rtl/lst_stop_monitor.sv
module lst_stop_monitor #(
  parameter int unsigned LANES = 5
) (
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] stop_state,
  output logic             all_stop
);
  logic [LANES-1:0] lane_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_ok[i] = stop_state[i] | ~lane_en[i];
  end

  assign all_stop = &lane_ok;
endmodule

// File: rtl/lst_prescaler.sv
module lst_prescaler
  import lst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  input  logic x16,
  input  logic x4,
  output logic tick
);
  logic [PRE_W-1:0] term_q;
  logic [PRE_W-1:0] cnt_q;

  assign tick = adv && (cnt_q == term_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      term_q <= pre_term(x16, x4);
      cnt_q  <= '0;
    end else if (adv) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end

  // R6: the prescaler never runs past its terminal value
  a_r6_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_q);
endmodule

// File: rtl/lst_main_counter.sv
module lst_main_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  assign last = dec && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  // R6: a running count never decrements through zero
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt_q != '0);
endmodule

// File: rtl/lane_stop_timeout.sv
module lane_stop_timeout #(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned LANES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_set,
  input  logic             sw_clr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             scale_x16,
  input  logic             scale_x4,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] stop_state,
  output logic             force_rx,
  output logic             force_bit,
  output logic             done_pulse
);
  logic force_q, run_q, done_q;
  logic all_stop;
  logic tmr_load, tmr_adv, pre_tick, main_last, expire;

  lst_stop_monitor #(.LANES(LANES)) u_mon (
    .lane_en(lane_en), .stop_state(stop_state), .all_stop(all_stop));

  assign tmr_load = force_q && all_stop && !run_q && !sw_clr;
  assign tmr_adv  = force_q && all_stop &&  run_q && !sw_clr;

  lst_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .adv(tmr_adv),
    .x16(scale_x16), .x4(scale_x4), .tick(pre_tick));

  lst_main_counter #(.CNT_W(CNT_W)) u_main (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(cnt_val),
    .dec(pre_tick), .last(main_last));

  assign expire = (tmr_load && cnt_val == '0) || main_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= 1'b0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= expire;
      if (sw_clr) begin
        force_q <= 1'b0;
        run_q   <= 1'b0;
      end else if (!force_q) begin
        force_q <= sw_set;
        run_q   <= 1'b0;
      end else if (!all_stop || expire) begin
        force_q <= !expire;
        run_q   <= 1'b0;
      end else begin
        run_q <= 1'b1;
      end
    end
  end

  assign force_rx   = force_q;
  assign force_bit  = force_q;
  assign done_pulse = done_q;

  // R2: a clear always drops force and suppresses the done pulse
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> !force_rx && !done_pulse);
  // R1: a set from idle raises force next cycle
  a_r1_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    !force_rx && sw_set && !sw_clr |=> force_rx);
  // R8: done only coincides with a fall of force
  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !force_rx && $past(force_rx));
  // R8: done never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  // R5: a lane leaving stop state cannot finish the timeout
  a_r5_reload_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    force_rx && !all_stop |=> !done_pulse);
  // R7: zero count finishes on the loading cycle
  a_r7_zero_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_load && cnt_val == '0 |=> done_pulse && !force_rx);
endmodule

// File: tb/lane_stop_timeout_tb.sv
`timescale 1ns/1ps
module lane_stop_timeout_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_set = 0, sw_clr = 0, x16 = 0, x4 = 0;
  logic [12:0] cnt = '0;
  logic [4:0] en = '1, stop = '0;
  logic force_rx, force_bit, done_pulse;

  int vectors = 0, fails = 0;
  bit finished = 0;

  // reference model state
  bit m_force = 0, m_done = 0;
  int m_n = 0, m_d = 0;

  always #2 clk = ~clk;

  lane_stop_timeout dut_i (
    .clk(clk), .rst_n(rst_n), .sw_set(sw_set), .sw_clr(sw_clr),
    .cnt_val(cnt), .scale_x16(x16), .scale_x4(x4), .lane_en(en),
    .stop_state(stop), .force_rx(force_rx), .force_bit(force_bit),
    .done_pulse(done_pulse));

  function automatic int delay_of(input int c, input bit s16, input bit s4);
    int m = 1;
    if (s16) m = m * 16;
    if (s4)  m = m * 4;
    return c * m;
  endfunction

  function automatic bit lanes_stopped(input logic [4:0] e, input logic [4:0] s);
    for (int i = 0; i < 5; i++) if (e[i] && !s[i]) return 0;
    return 1;
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (force_rx !== m_force || force_bit !== m_force || done_pulse !== m_done) begin
      fails++;
      $display("FAIL %s: force_rx=%b force_bit=%b done=%b expected force=%b done=%b",
               tag, force_rx, force_bit, done_pulse, m_force, m_done);
    end
  endtask

  task automatic cyc(input string tag);
    bit s = sw_set, c = sw_clr, a = lanes_stopped(en, stop);
    int d = delay_of(cnt, x16, x4);
    @(posedge clk);
    #1;
    m_done = 0;
    if (!rst_n) begin m_force = 0; m_n = 0; end
    else if (c) begin m_force = 0; m_n = 0; end
    else if (!m_force) begin m_force = s; m_n = 0; end
    else if (!a) m_n = 0;
    else begin
      if (m_n == 0) m_d = d;
      m_n++;
      if (m_n == m_d + 1) begin m_force = 0; m_done = 1; m_n = 0; end
    end
    check(tag);
  endtask

  task automatic pulse_set(input string tag);
    sw_set = 1; cyc(tag); sw_set = 0;
  endtask

  task automatic clear(input string tag);
    sw_clr = 1; cyc(tag); sw_clr = 0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    #(4ns * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5EED_1234);
    // R9 reset state
    run(3, "R9");
    rst_n = 1;
    run(2, "R9");
    // R1 set, R4 held while lanes not stopped
    cnt = 3; stop = 5'h00;
    pulse_set("R1");
    run(10, "R4");
    pulse_set("R1");              // set while high: no change
    stop = 5'h1F;
    run(6, "R6");
    // R7 zero count
    cnt = 0; stop = 5'h1F;
    pulse_set("R7");
    run(3, "R7");
    // R3 disabled lanes ignored
    en = 5'b00101; stop = 5'b00101; cnt = 2; x4 = 1;
    pulse_set("R3");
    run(12, "R3");
    stop = 5'b00000; en = 5'b00010;
    pulse_set("R3");
    stop = 5'b00010;
    run(4, "R3");
    clear("R2");
    // R5 reload on lane drop, including drop on the final cycle
    en = 5'h1F; stop = 5'h1F; cnt = 5; x4 = 0;
    pulse_set("R5");
    run(3, "R5");
    stop = 5'h1B; cyc("R5"); stop = 5'h1F;
    run(5, "R5");
    stop = 5'h0F; cyc("R5"); stop = 5'h1F;
    run(8, "R5");
    // R10 scaling sampled at load
    cnt = 4; x16 = 0;
    pulse_set("R10");
    run(2, "R10");
    x16 = 1; cnt = 100;
    run(6, "R10");
    x16 = 0;
    // R2 set with clear, clear on final cycle
    sw_set = 1; sw_clr = 1; cyc("R2"); sw_set = 0; sw_clr = 0;
    run(2, "R2");
    cnt = 3; pulse_set("R2");
    run(3, "R2");
    clear("R2");
    run(2, "R2");
    // R6 long scaled delay, R8 pulse
    cnt = 100; x16 = 1; x4 = 1;
    pulse_set("R6");
    run(6410, "R8");
    x16 = 0; x4 = 0;
    // random mix
    for (int i = 0; i < 4000; i++) begin
      sw_set = ($urandom % 4) == 0;
      sw_clr = ($urandom % 40) == 0;
      if (($urandom % 16) == 0) begin
        cnt = 13'($urandom % 12); x16 = ($urandom % 4) == 0; x4 = $urandom % 2;
      end
      if (!m_force && ($urandom % 8) == 0) en = 5'($urandom);
      stop = (($urandom % 10) == 0) ? 5'($urandom) : 5'h1F;
      cyc("R6");
    end
    sw_set = 0; sw_clr = 0;
    run(4, "R8");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule